// File: doc/BRIEF.md
# JTAG Master TAP State Navigator

This block is the host side of a JTAG link. It drives TCK, TMS and TDI toward a target scan chain and keeps its own shadow copy of the state of the target's 16-state TAP controller. A single command moves the chain from wherever it is to any requested TAP state. A second command parks the chain in a stable state for a programmed number of TCK cycles. A third command forces a fresh recovery into Run-Test/Idle.

Each navigation step reads one word of a 16-entry by 16-bit next-step table. The current shadow state selects the word, and the bit at the requested state's index gives the TMS level for that step. The shadow then follows the standard TAP transition for that level. After reset the shadow state is unknown. The first command that needs a known state therefore starts with a recovery sequence.

The engine issues at most one TCK per pulse on `tckEn`, so the surrounding logic sets the TCK rate. Scan shifting, TCK frequency generation and real-time delays belong to other blocks.

Top module: `tap_nav_top`

## Requirements
- R1: After reset, `busy`, `done` and `stateKnown` are 0, and `tck`, `tms` are 1.
- R2: The recovery sequence is five TCK cycles with TMS high, then one with TMS low, after which `tapState` is Idle and `stateKnown` is 1. It runs before any goto or wait while the shadow is unknown, and it runs on every reset command (`cmdOp`=2). The reset command then ends with no further clocks.
- R3: A goto (`cmdOp`=0, target on `cmdState`) takes at most 9 TCKs. It ends with `tapState` equal to the target, the target chain in that state, and `cmdErr`=0. State codes: 0 Reset, 1 Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR.
- R4: A goto to the current state gives one TCK with TMS low if the state is Idle, Shift-DR, Pause-DR, Shift-IR or Pause-IR. It gives one TCK with TMS high if the state is Reset. For any other state it gives no TCK.
- R5: A wait (`cmdOp`=1) first moves to the target and then issues exactly `cmdCycles` TCKs. TMS is high during these TCKs if the target is Reset and low otherwise. If the target is already current, no extra dwell TCK is issued. A wait on a non-stable target ends with `cmdErr`=1, no TCK and an unchanged state.
- R6: TMS changes only together with a falling TCK edge and is stable at each rising edge. No TCK is issued while `tckEn` stays low.
- R7: `cmdValid` is accepted only while `busy`=0, and commands presented while busy are ignored. Each accepted command yields one single-cycle `done` pulse, and `cmdErr` is valid with it.
- R8: TDI is held low at all times.
- R9: The reserved command (`cmdOp`=3) ends with `cmdErr`=1, no TCK and `tapState` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tckEn | input | 1 | One pulse permits one TCK cycle |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 goto, 1 wait, 2 reset, 3 reserved |
| cmdState | input | 4 | Target TAP state code |
| cmdCycles | input | CYC_W | Dwell cycles for a wait |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cmdErr | output | 1 | Error status of the finished command |
| tapState | output | 4 | Shadow TAP state |
| stateKnown | output | 1 | Shadow state is valid |
| tck | output | 1 | Test clock to the chain |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data in (held low) |

## Verification
The bench runs a TAP slave model that is clocked by `tck`. That model starts in a state other than Reset. A design that skipped or shortened the recovery would therefore leave the model and the shadow out of step, which the bench reports after the first goto.

Repeated gotos to the same state cover the dwell rule for stable, Reset and transient states. A wrong dwell would show up as an extra or missing TCK, or as a model that has drifted.

Waits are tested with a zero count, with a Reset target and with a non-stable target. A faulty counter gives the wrong number of TCKs or the wrong TMS level. A missing stability check moves the chain.

Stalled enables and commands sent while busy expose a design that clocks without permission or accepts a second target.

// File: rtl/tap_nav_pkg.sv
package tap_nav_pkg;

  localparam logic [3:0] TS_RESET    = 4'd0;
  localparam logic [3:0] TS_IDLE     = 4'd1;
  localparam logic [3:0] TS_SEL_DR   = 4'd2;
  localparam logic [3:0] TS_CAP_DR   = 4'd3;
  localparam logic [3:0] TS_SHIFT_DR = 4'd4;
  localparam logic [3:0] TS_EX1_DR   = 4'd5;
  localparam logic [3:0] TS_PAUSE_DR = 4'd6;
  localparam logic [3:0] TS_EX2_DR   = 4'd7;
  localparam logic [3:0] TS_UPD_DR   = 4'd8;
  localparam logic [3:0] TS_SEL_IR   = 4'd9;
  localparam logic [3:0] TS_CAP_IR   = 4'd10;
  localparam logic [3:0] TS_SHIFT_IR = 4'd11;
  localparam logic [3:0] TS_EX1_IR   = 4'd12;
  localparam logic [3:0] TS_PAUSE_IR = 4'd13;
  localparam logic [3:0] TS_EX2_IR   = 4'd14;
  localparam logic [3:0] TS_UPD_IR   = 4'd15;

  localparam logic [1:0] OP_GOTO  = 2'd0;
  localparam logic [1:0] OP_WAIT  = 2'd1;
  localparam logic [1:0] OP_RESET = 2'd2;
  localparam logic [1:0] OP_RSVD  = 2'd3;

  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic stepGo;    // request one TCK cycle
    logic stepTms;   // TMS level for that cycle
    logic markIdle;  // recovery finished: shadow becomes Idle
  } navStrobe_t;

  // standard TAP graph: successor of a state for a TMS level
  function automatic logic [3:0] tapNext(input logic [3:0] s, input logic m);
    logic [3:0] n;
    case (s)
      TS_RESET:    n = m ? TS_RESET  : TS_IDLE;
      TS_IDLE:     n = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR:   n = m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR:   n = m ? TS_EX1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = m ? TS_EX1_DR : TS_SHIFT_DR;
      TS_EX1_DR:   n = m ? TS_UPD_DR : TS_PAUSE_DR;
      TS_PAUSE_DR: n = m ? TS_EX2_DR : TS_PAUSE_DR;
      TS_EX2_DR:   n = m ? TS_UPD_DR : TS_SHIFT_DR;
      TS_UPD_DR:   n = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR:   n = m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR:   n = m ? TS_EX1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = m ? TS_EX1_IR : TS_SHIFT_IR;
      TS_EX1_IR:   n = m ? TS_UPD_IR : TS_PAUSE_IR;
      TS_PAUSE_IR: n = m ? TS_EX2_IR : TS_PAUSE_IR;
      TS_EX2_IR:   n = m ? TS_UPD_IR : TS_SHIFT_IR;
      default:     n = m ? TS_SEL_DR : TS_IDLE;
    endcase
    return n;
  endfunction

  // next-step word per current state; bit [target] is the TMS level
  function automatic logic [15:0] stepWord(input logic [3:0] s);
    logic [15:0] w;
    case (s)
      4'd0:  w = 16'h0001;
      4'd1:  w = 16'hFFFD;
      4'd2:  w = 16'hFE01;
      4'd3:  w = 16'hFFE7;
      4'd4:  w = 16'hFFEF;
      4'd5:  w = 16'hFF0F;
      4'd6:  w = 16'hFFBF;
      4'd7:  w = 16'hFFFF;
      4'd8:  w = 16'hFEFD;
      4'd9:  w = 16'h0001;
      4'd10: w = 16'hF3FF;
      4'd11: w = 16'hF7FF;
      4'd12: w = 16'h87FF;
      4'd13: w = 16'hDFFF;
      4'd14: w = 16'hFFFF;
      default: w = 16'h7FFD;
    endcase
    return w;
  endfunction

  function automatic logic isStable(input logic [3:0] s);
    return (s == TS_RESET) || (s == TS_IDLE) || (s == TS_SHIFT_DR) ||
           (s == TS_PAUSE_DR) || (s == TS_SHIFT_IR) || (s == TS_PAUSE_IR);
  endfunction

endpackage

// File: rtl/tap_nav_dp.sv
module tap_nav_dp
  import tap_nav_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tckEn,
  input  navStrobe_t strb,
  input  logic [3:0] target,
  output logic [3:0] curState,
  output logic       known,
  output logic       pending,
  output logic       stepAccept,
  output logic       pathTms,
  output logic       tck,
  output logic       tms
);

  logic [15:0] word;

  assign word       = stepWord(curState);
  assign pathTms    = word[target];
  assign stepAccept = strb.stepGo && tckEn && !pending;

  // falling edge with new TMS on accept, rising edge one clk later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tck      <= 1'b1;
      tms      <= 1'b1;
      pending  <= 1'b0;
      curState <= TS_RESET;
      known    <= 1'b0;
    end else begin
      if (stepAccept) begin
        tck     <= 1'b0;
        tms     <= strb.stepTms;
        pending <= 1'b1;
      end else if (pending) begin
        tck     <= 1'b1;
        pending <= 1'b0;
        if (known) curState <= tapNext(curState, tms);
      end
      if (strb.markIdle) begin
        curState <= TS_IDLE;
        known    <= 1'b1;
      end
    end
  end

  AST_TMS_HOLD_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tck) |-> $stable(tms)); // R6
  AST_TCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tck) |-> $past(tckEn)); // R6
  AST_MARK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.markIdle |=> (known && curState == TS_IDLE)); // R2
  AST_KNOWN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    known |=> known); // R3

endmodule

// File: rtl/tap_nav_ctl.sv
module tap_nav_ctl
  import tap_nav_pkg::*;
#(
  parameter int CYC_W       = 16,
  parameter int MAX_STEPS   = 9,
  parameter int RESET_HIGHS = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [3:0]       cmdState,
  input  logic [CYC_W-1:0] cmdCycles,
  input  logic [3:0]       curState,
  input  logic             known,
  input  logic             pending,
  input  logic             stepAccept,
  input  logic             pathTms,
  output navStrobe_t       strb,
  output logic [3:0]       target,
  output logic             busy,
  output logic             done,
  output logic             cmdErr
);

  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam int INIT_W = $clog2(RESET_HIGHS + 2);
  localparam logic [STEP_W-1:0] STEP_LIM  = STEP_W'(MAX_STEPS);
  localparam logic [INIT_W-1:0] INIT_HIGH = INIT_W'(RESET_HIGHS);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(RESET_HIGHS + 1);

  typedef enum logic [2:0] {
    C_IDLE, C_INIT, C_ENTRY, C_NAV, C_DWELL, C_WAIT, C_FINISH
  } ctlSt_e;

  ctlSt_e            st;
  logic [1:0]        opQ;
  logic [3:0]        tgtQ;
  logic [CYC_W-1:0]  cycLeft;
  logic [STEP_W-1:0] navCnt;
  logic [INIT_W-1:0] initCnt;
  logic              errQ;
  logic              dwellDone;

  assign target = tgtQ;
  assign busy   = (st != C_IDLE);
  assign done   = (st == C_FINISH);
  assign cmdErr = errQ;

  always_comb begin
    strb = '0;
    case (st)
      C_INIT:
        if (!pending) begin
          if (initCnt == INIT_LAST) strb.markIdle = 1'b1;
          else begin
            strb.stepGo  = 1'b1;
            strb.stepTms = (initCnt < INIT_HIGH);
          end
        end
      C_NAV:
        if (!pending && curState != tgtQ && navCnt < STEP_LIM) begin
          strb.stepGo  = 1'b1;
          strb.stepTms = pathTms;
        end
      C_DWELL:
        if (!pending && !dwellDone) begin
          strb.stepGo  = 1'b1;
          strb.stepTms = (tgtQ == TS_RESET);
        end
      C_WAIT:
        if (!pending && cycLeft != '0) begin
          strb.stepGo  = 1'b1;
          strb.stepTms = (tgtQ == TS_RESET);
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= C_IDLE;
      opQ       <= OP_GOTO;
      tgtQ      <= TS_RESET;
      cycLeft   <= '0;
      navCnt    <= '0;
      initCnt   <= '0;
      errQ      <= 1'b0;
      dwellDone <= 1'b0;
    end else begin
      case (st)
        C_IDLE:
          if (cmdValid) begin
            opQ       <= cmdOp;
            tgtQ      <= cmdState;
            cycLeft   <= cmdCycles;
            navCnt    <= '0;
            initCnt   <= '0;
            dwellDone <= 1'b0;
            errQ      <= 1'b0;
            if (cmdOp == OP_RSVD || (cmdOp == OP_WAIT && !isStable(cmdState))) begin
              errQ <= 1'b1;
              st   <= C_FINISH;
            end else if (cmdOp == OP_RESET || !known) st <= C_INIT;
            else st <= C_ENTRY;
          end
        C_INIT: begin
          if (stepAccept) initCnt <= initCnt + 1'b1;
          if (strb.markIdle) st <= (opQ == OP_RESET) ? C_FINISH : C_ENTRY;
        end
        C_ENTRY:
          if (curState == tgtQ) begin
            if (opQ == OP_GOTO) st <= isStable(tgtQ) ? C_DWELL : C_FINISH;
            else st <= C_WAIT;
          end else st <= C_NAV;
        C_NAV: begin
          if (stepAccept) navCnt <= navCnt + 1'b1;
          if (!pending) begin
            if (curState == tgtQ) st <= (opQ == OP_WAIT) ? C_WAIT : C_FINISH;
            else if (navCnt == STEP_LIM) begin
              errQ <= 1'b1;
              st   <= C_FINISH;
            end
          end
        end
        C_DWELL: begin
          if (stepAccept) dwellDone <= 1'b1;
          if (!pending && dwellDone) st <= C_FINISH;
        end
        C_WAIT: begin
          if (stepAccept) cycLeft <= cycLeft - 1'b1;
          if (!pending && cycLeft == '0) st <= C_FINISH;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  AST_NAV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (st == C_NAV) |-> (navCnt <= STEP_LIM)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_WAIT_AT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (st == C_WAIT && stepAccept) |-> (curState == tgtQ)); // R5
  AST_BUSY_HOLDS_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(tgtQ)); // R7

endmodule

// File: rtl/tap_nav_top.sv
module tap_nav_top
  import tap_nav_pkg::*;
#(
  parameter int CYC_W       = 16,
  parameter int MAX_STEPS   = 9,
  parameter int RESET_HIGHS = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tckEn,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [3:0]       cmdState,
  input  logic [CYC_W-1:0] cmdCycles,
  output logic             busy,
  output logic             done,
  output logic             cmdErr,
  output logic [3:0]       tapState,
  output logic             stateKnown,
  output logic             tck,
  output logic             tms,
  output logic             tdi
);

  navStrobe_t strb;
  logic [3:0] target;
  logic       pending;
  logic       stepAccept;
  logic       pathTms;

  assign tdi = 1'b0;  // navigation never shifts data

  tap_nav_ctl #(
    .CYC_W(CYC_W), .MAX_STEPS(MAX_STEPS), .RESET_HIGHS(RESET_HIGHS)
  ) uCtl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdState(cmdState), .cmdCycles(cmdCycles),
    .curState(tapState), .known(stateKnown), .pending(pending),
    .stepAccept(stepAccept), .pathTms(pathTms),
    .strb(strb), .target(target), .busy(busy), .done(done), .cmdErr(cmdErr)
  );

  tap_nav_dp uDp (
    .clk(clk), .rstN(rstN), .tckEn(tckEn), .strb(strb), .target(target),
    .curState(tapState), .known(stateKnown), .pending(pending),
    .stepAccept(stepAccept), .pathTms(pathTms), .tck(tck), .tms(tms)
  );

endmodule

// File: tb/tb_tap_nav_top.sv
`timescale 1ns/1ps
module tb_tap_nav_top;

  localparam int CYC_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tckEn = 1'b0;
  logic             cmdValid = 1'b0;
  logic [1:0]       cmdOp = 2'd0;
  logic [3:0]       cmdState = 4'd0;
  logic [CYC_W-1:0] cmdCycles = '0;
  logic             busy, done, cmdErr, stateKnown, tck, tms, tdi;
  logic [3:0]       tapState;

  int  vectors = 0;
  int  miscomp = 0;
  bit  enGate = 1'b0;
  bit  finished = 1'b0;
  int  logIdx = 0;
  bit  tmsLog [64];
  logic [3:0] refState = 4'd7;   // target chain powers up away from Reset
  int  tdiBad = 0;
  int  tmsBad = 0;
  int  doneCnt = 0;
  logic prevTms = 1'b1;
  bit  lastErr;

  tap_nav_top #(.CYC_W(CYC_W)) dut (
    .clk(clk), .rstN(rstN), .tckEn(tckEn), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdState(cmdState), .cmdCycles(cmdCycles), .busy(busy), .done(done),
    .cmdErr(cmdErr), .tapState(tapState), .stateKnown(stateKnown),
    .tck(tck), .tms(tms), .tdi(tdi)
  );

  always #2.5 clk = ~clk;

  // reference TAP slave, per the standard state graph
  function automatic logic [3:0] slaveNext(input logic [3:0] s, input logic m);
    case (s)
      4'd0:  return m ? 4'd0  : 4'd1;
      4'd1:  return m ? 4'd2  : 4'd1;
      4'd2:  return m ? 4'd9  : 4'd3;
      4'd3:  return m ? 4'd5  : 4'd4;
      4'd4:  return m ? 4'd5  : 4'd4;
      4'd5:  return m ? 4'd8  : 4'd6;
      4'd6:  return m ? 4'd7  : 4'd6;
      4'd7:  return m ? 4'd8  : 4'd4;
      4'd8:  return m ? 4'd2  : 4'd1;
      4'd9:  return m ? 4'd0  : 4'd10;
      4'd10: return m ? 4'd12 : 4'd11;
      4'd11: return m ? 4'd12 : 4'd11;
      4'd12: return m ? 4'd15 : 4'd13;
      4'd13: return m ? 4'd14 : 4'd13;
      4'd14: return m ? 4'd15 : 4'd11;
      default: return m ? 4'd2 : 4'd1;
    endcase
  endfunction

  function automatic bit parkable(input int s);
    return s == 0 || s == 1 || s == 4 || s == 6 || s == 11 || s == 13;
  endfunction

  always @(posedge tck) begin
    refState = slaveNext(refState, tms);
    if (logIdx < 64) tmsLog[logIdx] = tms;
    logIdx++;
  end

  initial forever begin
    @(negedge clk);
    tckEn = enGate && (($urandom % 4) != 0);
  end

  initial forever begin
    @(negedge clk);
    if (rstN) begin
      if (tdi !== 1'b0) tdiBad++;
      if (tms !== prevTms && tck !== 1'b0) tmsBad++;
      if (done) doneCnt++;
    end
    prevTms = tms;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input int st, input int cyc);
    while (busy) @(negedge clk);
    logIdx = 0;
    cmdOp = op; cmdState = 4'(st); cmdCycles = CYC_W'(cyc);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!done) @(negedge clk);
    lastErr = cmdErr;
    @(negedge clk);
  endtask

  task automatic chkGoto(input int t, input string req);
    chk(refState == 4'(t), req, refState, t);
    chk(tapState == refState, req, tapState, refState);
    chk(lastErr == 1'b0, req, lastErr, 0);
  endtask

  initial begin
    #1000000;
    chk(1'b0, "R7 watchdog", 0, 1);
    finish();
  end

  initial begin
    int prev;
    int savedSt;
    int n;
    bit ok;
    void'($urandom(32'h5EED_7A11));
    repeat (5) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(stateKnown == 0, "R1 known", stateKnown, 0);
    chk(tck == 1 && tms == 1, "R1 pins", {tck, tms}, 3);
    rstN = 1'b1;
    enGate = 1'b1;
    @(negedge clk);

    // R2: recovery on first goto
    doCmd(2'd0, 4, 0);
    ok = 1;
    for (int i = 0; i < 5; i++) if (!tmsLog[i]) ok = 0;
    chk(ok && !tmsLog[5], "R2 recovery TMS pattern", tmsLog[5], 0);
    chk(stateKnown == 1, "R2 known", stateKnown, 1);
    chkGoto(4, "R3 first goto");

    // R3/R4: random gotos
    prev = 4;
    for (int k = 0; k < 60; k++) begin
      int t = int'($urandom % 16);
      doCmd(2'd0, t, 0);
      chkGoto(t, "R3 random goto");
      if (prev != t) chk(logIdx >= 1 && logIdx <= 9, "R3 step bound", logIdx, 9);
      else chk(logIdx == (parkable(t) ? 1 : 0), "R4 dwell count", logIdx, parkable(t) ? 1 : 0);
      prev = t;
    end

    // R4 directed
    doCmd(2'd0, 4, 0); doCmd(2'd0, 4, 0);
    chk(logIdx == 1 && tmsLog[0] == 0, "R4 dwell Shift-DR", logIdx, 1);
    doCmd(2'd0, 0, 0); doCmd(2'd0, 0, 0);
    chk(logIdx == 1 && tmsLog[0] == 1, "R4 dwell Reset", logIdx, 1);
    doCmd(2'd0, 2, 0); doCmd(2'd0, 2, 0);
    chk(logIdx == 0 && refState == 4'd2, "R4 no dwell Select-DR", logIdx, 0);

    // R5 waits
    doCmd(2'd0, 13, 0); doCmd(2'd1, 13, 7);
    ok = 1;
    for (int i = 0; i < 7; i++) if (tmsLog[i]) ok = 0;
    chk(ok && logIdx == 7 && refState == 4'd13, "R5 wait Pause-IR", logIdx, 7);
    doCmd(2'd0, 0, 0); doCmd(2'd1, 0, 3);
    chk(logIdx == 3 && tmsLog[0] && tmsLog[1] && tmsLog[2] && refState == 0,
        "R5 wait Reset TMS high", logIdx, 3);
    doCmd(2'd1, 11, 0);
    chkGoto(11, "R5 wait zero cycles");
    doCmd(2'd1, 5, 4);
    chk(lastErr == 1 && logIdx == 0 && refState == 4'd11, "R5 non-stable wait", logIdx, 0);
    for (int k = 0; k < 12; k++) begin
      int t;
      do t = int'($urandom % 16); while (!parkable(t));
      n = int'($urandom % 20);
      doCmd(2'd1, t, n);
      chkGoto(t, "R5 random wait");
      ok = (logIdx >= n);
      for (int i = 0; i < n; i++)
        if (logIdx - n + i < 64 && tmsLog[logIdx - n + i] != (t == 0)) ok = 0;
      chk(ok, "R5 dwell TMS level", logIdx, n);
    end

    // R9 reserved op
    savedSt = int'(tapState);
    doCmd(2'd3, 6, 2);
    chk(lastErr == 1 && logIdx == 0 && tapState == 4'(savedSt), "R9 reserved op", logIdx, 0);

    // R2 explicit reset command
    doCmd(2'd0, 11, 0);
    doCmd(2'd2, 9, 0);
    ok = 1;
    for (int i = 0; i < 5; i++) if (!tmsLog[i]) ok = 0;
    chk(ok && !tmsLog[5] && logIdx == 6, "R2 reset command", logIdx, 6);
    chkGoto(1, "R2 reset ends Idle");

    // R6 stalled enable, R7 command while busy
    enGate = 1'b0;
    @(negedge clk);
    logIdx = 0;
    n = doneCnt;
    cmdOp = 2'd0; cmdState = 4'd4; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (40) @(negedge clk);
    chk(logIdx == 0 && busy == 1, "R6 no TCK without enable", logIdx, 0);
    cmdOp = 2'd0; cmdState = 4'd13; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    enGate = 1'b1;
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(refState == 4'd4 && tapState == 4'd4, "R7 busy command ignored", tapState, 4);
    chk(doneCnt - n == 1, "R7 single done", doneCnt - n, 1);

    chk(tmsBad == 0, "R6 TMS only on falling TCK", tmsBad, 0);
    chk(tdiBad == 0, "R8 TDI low", tdiBad, 0);
    finish();
  end

endmodule